// File: doc/BRIEF.md
# I2C Slave Transmitter with Clock Stretching

This block is the target side of an I2C link for read transfers. It watches the bus for a START, shifts in the first byte after it and compares the upper seven bits with its own address. On a match it pulls SDA low during the ninth clock as the acknowledge. If the direction bit of that byte asks for a read, it switches itself into transmit mode and then serves data bytes to the master, MSB first, one bit per SCL period.

The host side sees a data register that is separate from the shift register. When the data register is empty at the end of a frame, the block holds SCL low. This stalls the master until the host writes the next byte. If the host has already written the next byte before the frame ends, that byte moves into the shift register at once and the bus is not held. At the end of a transfer, the host clears the stored acknowledge and the direction bit. It then issues one dummy read of the data register, which frees SCL. Both bus outputs are pull-low enables, so the block never drives a line high.

Control is one state machine:
- `ST_IDLE`: waits for a START.
- `ST_ADDR`: receives the address byte.
- `ST_ADDR_ACK`: acknowledges the address.
- `ST_TX_BIT`: shifts out data bits.
- `ST_TX_ACK`: releases SDA while the master acknowledges.
- `ST_HOLD`: stretches SCL.
- `ST_IGNORE`: sits out a transfer not meant for this block.

Transitions:
- START from any state goes to `ST_ADDR`. STOP from any state goes to `ST_IDLE`.
- `ST_ADDR` → `ST_ADDR_ACK` on the eighth falling edge when the address matches. It goes to `ST_IGNORE` when the address does not match.
- `ST_ADDR_ACK` → `ST_IGNORE` for a write request. For a read request it goes to `ST_TX_BIT` if data is waiting, and to `ST_HOLD` otherwise.
- `ST_TX_BIT` → `ST_TX_ACK` after the eighth data bit.
- `ST_TX_ACK` → `ST_TX_BIT` if the next byte is ready, and to `ST_HOLD` otherwise.
- `ST_HOLD` → `ST_TX_BIT` after a data write, or to `ST_IDLE` after a dummy read.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset both pull-low outputs are 0, `dr_empty` is 1, and `frame_flag`, `ack_stat`, `dir_tx` and `irq` are 0.
- R2: The first byte after a START is the address, with the 7-bit address in bits 7..1 and the read request (bit 0 = 1) last. When the address equals `OWN_ADDR` and bit 0 is 1, SDA is pulled low through the ninth clock. At the ninth rising edge, `dir_tx`, `frame_flag` and `dr_empty` all become 1.
- R3: A first byte whose address differs from `OWN_ADDR` gets no acknowledge. It sets no flag, and the block releases both lines until the next START.
- R4: `irq` is 1 exactly while `frame_flag` and `irq_en` are both 1.
- R5: If `dr_empty` is 1 at the ninth falling edge of a read frame, `scl_low` goes to 1 and stays 1 until the data register is written or dummy-read.
- R6: A data write clears `dr_empty`. While the bus is held, the written byte then moves to the shift register, which sets `dr_empty` and `frame_flag` to 1 and releases SCL. Its bits appear on SDA MSB first, one per SCL period, and SDA changes only while SCL is low.
- R7: At the ninth rising edge of each transmitted byte, the SDA level from the master is stored in `ack_stat` (0 = acknowledge, 1 = no acknowledge).
- R8: If the data register was written during a byte, then at that byte's ninth rising edge the new data moves into the shift register and `dr_empty` and `frame_flag` become 1. SCL is not held after the ninth falling edge.
- R9: A pulse on `ack_clr` clears `ack_stat`. A pulse on `dir_clr` clears `dir_tx`. A pulse on `flag_clr` clears `frame_flag`.
- R10: A pulse on `dr_rd` while SCL is held releases SCL and returns the block to idle.
- R11: A STOP (SDA rising while SCL is high) returns the block to idle with both lines released. Later clock pulses without a START get no response.
- R12: A matching address with bit 0 = 0 is acknowledged but leaves `dir_tx` and `frame_flag` unchanged, and SCL is not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| scl_low | output | 1 | 1 pulls SCL low (stretch) |
| sda_low | output | 1 | 1 pulls SDA low |
| irq_en | input | 1 | Interrupt enable |
| dr_wr | input | 1 | Write strobe for the data register |
| dr_wdata | input | 8 | Write data for the data register |
| dr_rd | input | 1 | Read strobe for the data register (dummy read) |
| flag_clr | input | 1 | Clears the frame flag |
| ack_clr | input | 1 | Acknowledge-enable cleared: clears the stored acknowledge |
| dir_clr | input | 1 | Clears the direction bit |
| dr_empty | output | 1 | Data register empty flag |
| frame_flag | output | 1 | Frame interrupt flag |
| ack_stat | output | 1 | Stored master acknowledge bit |
| dir_tx | output | 1 | Direction bit, 1 = transmitting |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: own address 0x2A and a two-stage input synchronizer. The bench models the bus as wired-AND. The address 0x2A lets the bench send a matching read byte (0x55), a matching write byte (0x54) and a foreign read byte (0x23), so the acknowledge, ignore and write paths can all be reached in one run. With two sync stages, each bus edge reaches the state machine three clocks later. This is short compared with the bench's 20-clock half period, so the bench can sample the flags in the middle of the ninth high phase and sample the hold shortly after the ninth fall.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_TX_BIT,
        ST_TX_ACK,
        ST_HOLD,
        ST_IGNORE
    } slv_state_e;
endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_slv_cond.sv
module i2c_slv_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
        end
    end

    assign scl_rise  = scl & ~scl_d;
    assign scl_fall  = ~scl & scl_d;
    assign start_det = scl & scl_d & sda_d & ~sda;
    assign stop_det  = scl & scl_d & ~sda_d & sda;
endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
    import i2c_slv_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR    = 7'h2A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_low,
    output logic              sda_low,
    input  logic              irq_en,
    input  logic              dr_wr,
    input  logic [BYTE_W-1:0] dr_wdata,
    input  logic              dr_rd,
    input  logic              flag_clr,
    input  logic              ack_clr,
    input  logic              dir_clr,
    output logic              dr_empty,
    output logic              frame_flag,
    output logic              ack_stat,
    output logic              dir_tx,
    output logic              irq
);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] TX_LAST   = CNT_W'(BYTE_W - 1);

    logic [1:0] line_raw, line_s;
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    assign line_raw = {sda_in, scl_in};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        i2c_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(line_raw[g]), .q(line_s[g])
        );
    end

    assign scl_s = line_s[0];
    assign sda_s = line_s[1];

    i2c_slv_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    slv_state_e        state, nxt;
    logic [BYTE_W-1:0] dr, sh;
    logic [CNT_W-1:0]  bit_cnt;
    logic              rw_q, sh_full, addr_hit;

    assign addr_hit = (sh[BYTE_W-1:1] == OWN_ADDR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_det)       nxt = ST_IDLE;
        else if (start_det) nxt = ST_ADDR;
        else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: nxt = state;
                ST_ADDR:
                    if (scl_fall && bit_cnt == ADDR_LAST)
                        nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:
                    if (scl_fall)
                        nxt = !rw_q ? ST_IGNORE : (dr_empty ? ST_HOLD : ST_TX_BIT);
                ST_TX_BIT:
                    if (scl_fall && bit_cnt == TX_LAST) nxt = ST_TX_ACK;
                ST_TX_ACK:
                    if (scl_fall) nxt = (sh_full || !dr_empty) ? ST_TX_BIT : ST_HOLD;
                ST_HOLD:
                    if (!dr_empty)  nxt = ST_TX_BIT;
                    else if (dr_rd) nxt = ST_IDLE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr         <= '0;
            sh         <= '0;
            bit_cnt    <= '0;
            dr_empty   <= 1'b1;
            frame_flag <= 1'b0;
            ack_stat   <= 1'b0;
            dir_tx     <= 1'b0;
            rw_q       <= 1'b0;
            sh_full    <= 1'b0;
        end else begin
            if (flag_clr) frame_flag <= 1'b0;
            if (ack_clr)  ack_stat   <= 1'b0;
            if (dir_clr)  dir_tx     <= 1'b0;
            if (dr_wr) begin
                dr       <= dr_wdata;
                dr_empty <= 1'b0;
            end
            if (start_det || stop_det) begin
                bit_cnt <= '0;
                sh_full <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            sh      <= {sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (scl_fall && bit_cnt == ADDR_LAST) rw_q <= sh[0];
                    end
                    ST_ADDR_ACK: begin
                        if (scl_rise && rw_q) begin
                            dir_tx     <= 1'b1;
                            frame_flag <= 1'b1;
                            dr_empty   <= 1'b1;
                        end
                        if (scl_fall && rw_q && !dr_empty) begin
                            sh         <= dr;
                            dr_empty   <= 1'b1;
                            frame_flag <= 1'b1;
                        end
                        if (scl_fall) bit_cnt <= '0;
                    end
                    ST_TX_BIT:
                        if (scl_fall) begin
                            sh      <= {sh[BYTE_W-2:0], 1'b0};
                            bit_cnt <= (bit_cnt == TX_LAST) ? '0 : bit_cnt + 1'b1;
                        end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            ack_stat   <= sda_s;
                            frame_flag <= 1'b1;
                            if (!dr_empty) begin
                                sh       <= dr;
                                sh_full  <= 1'b1;
                                dr_empty <= 1'b1;
                            end
                        end
                        if (scl_fall) begin
                            if (!sh_full && !dr_empty) begin
                                sh         <= dr;
                                dr_empty   <= 1'b1;
                                frame_flag <= 1'b1;
                            end
                            sh_full <= 1'b0;
                            bit_cnt <= '0;
                        end
                    end
                    ST_HOLD:
                        if (!dr_empty) begin
                            sh         <= dr;
                            dr_empty   <= 1'b1;
                            frame_flag <= 1'b1;
                            bit_cnt    <= '0;
                        end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_low = (state == ST_ADDR_ACK) || (state == ST_TX_BIT && !sh[BYTE_W-1]);
        scl_low = (state == ST_HOLD);
        irq     = frame_flag & irq_en;
    end

    assert_dir_on_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dir_tx) |-> ($past(state) == ST_ADDR_ACK && $past(scl_rise)));

    assert_hold_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_low) |-> ($past(dr_empty) && !$past(scl_s)));

    assert_sda_moves_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_low != $past(sda_low)) |-> !$past(scl_s));

    assert_frame_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_flag) |-> ($past(scl_rise) || $past(scl_fall) || $past(state) == ST_HOLD));

    assert_nack_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_stat) |-> ($past(state) == ST_TX_ACK && $past(scl_rise)));

    assert_stop_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !scl_low && !sda_low));
endmodule

// File: tb/tb_i2c_slave_tx.sv
module tb_i2c_slave_tx;
    localparam int H = 20;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mscl = 1'b1, msda = 1'b1;
    logic irq_en = 1'b0, dr_wr = 1'b0, dr_rd = 1'b0;
    logic flag_clr = 1'b0, ack_clr = 1'b0, dir_clr = 1'b0;
    logic [7:0] dr_wdata = 8'h00;
    logic scl_low, sda_low, dr_empty, frame_flag, ack_stat, dir_tx, irq;
    wire  scl_bus = mscl & ~scl_low;
    wire  sda_bus = msda & ~sda_low;
    int   tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    i2c_slave_tx dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_low(scl_low), .sda_low(sda_low), .irq_en(irq_en),
        .dr_wr(dr_wr), .dr_wdata(dr_wdata), .dr_rd(dr_rd),
        .flag_clr(flag_clr), .ack_clr(ack_clr), .dir_clr(dir_clr),
        .dr_empty(dr_empty), .frame_flag(frame_flag), .ack_stat(ack_stat),
        .dir_tx(dir_tx), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hi_begin();
        mscl = 1'b1;
        wait (scl_bus === 1'b1);
        idle(Q);
    endtask

    task automatic hi_end();
        idle(Q);
        mscl = 1'b0;
        idle(2);
    endtask

    task automatic put_bit(input logic b);
        msda = b; idle(H); hi_begin(); hi_end();
    endtask

    task automatic get_bit(output logic b);
        msda = 1'b1; idle(H); hi_begin(); b = sda_bus; hi_end();
    endtask

    task automatic put_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
    endtask

    task automatic get_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    endtask

    task automatic bus_start();
        msda = 1'b1; idle(2); mscl = 1'b1; idle(H);
        msda = 1'b0; idle(H); mscl = 1'b0; idle(2);
    endtask

    task automatic bus_stop();
        msda = 1'b0; idle(H); mscl = 1'b1;
        wait (scl_bus === 1'b1);
        idle(H); msda = 1'b1; idle(H);
    endtask

    // 0 write, 1 read, 2 flag clear, 3 ack clear, 4 dir clear
    task automatic cpu(input int op, input logic [7:0] d);
        @(negedge clk);
        case (op)
            0: begin dr_wr = 1'b1; dr_wdata = d; end
            1: dr_rd = 1'b1;
            2: flag_clr = 1'b1;
            3: ack_clr = 1'b1;
            default: dir_clr = 1'b1;
        endcase
        @(negedge clk);
        dr_wr = 1'b0; dr_rd = 1'b0; flag_clr = 1'b0; ack_clr = 1'b0; dir_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "scl_low", scl_low, 0);
        chk("R1", "sda_low", sda_low, 0);
        chk("R1", "dr_empty", dr_empty, 1);
        chk("R1", "frame_flag", frame_flag, 0);
        chk("R1", "ack_stat", ack_stat, 0);
        chk("R1", "dir_tx", dir_tx, 0);
        chk("R1", "irq", irq, 0);
    endtask

    task automatic t_mismatch();
        bus_start();
        put_byte(8'h23);
        msda = 1'b1; idle(H); hi_begin();
        chk("R3", "no ack", sda_bus, 1);
        chk("R3", "dir_tx", dir_tx, 0);
        chk("R3", "frame_flag", frame_flag, 0);
        hi_end(); idle(6);
        chk("R3", "scl free", scl_low, 0);
        bus_stop();
    endtask

    task automatic t_read();
        logic [7:0] v;
        irq_en = 1'b1;
        bus_start();
        put_byte(8'h55);
        msda = 1'b1; idle(H); hi_begin();
        chk("R2", "ack", sda_bus, 0);
        chk("R2", "dir_tx", dir_tx, 1);
        chk("R2", "frame_flag", frame_flag, 1);
        chk("R2", "dr_empty", dr_empty, 1);
        chk("R4", "irq enabled", irq, 1);
        chk("R5", "no hold before fall", scl_low, 0);
        hi_end(); idle(6);
        chk("R5", "hold after 9th fall", scl_low, 1);
        cpu(2, 0);
        chk("R4", "irq after clear", irq, 0);
        idle(20);
        chk("R5", "hold persists", scl_bus, 0);
        cpu(0, 8'hA5); idle(3);
        chk("R6", "empty after load", dr_empty, 1);
        chk("R6", "frame after load", frame_flag, 1);
        chk("R6", "scl released", scl_low, 0);
        cpu(2, 0);
        cpu(0, 8'h3C); idle(1);
        chk("R6", "write clears empty", dr_empty, 0);
        get_byte(v);
        chk("R6", "first byte", v, 8'hA5);
        msda = 1'b0; idle(H); hi_begin();
        chk("R8", "empty at 9th rise", dr_empty, 1);
        chk("R8", "frame at 9th rise", frame_flag, 1);
        chk("R7", "ack stored", ack_stat, 0);
        hi_end(); idle(6);
        chk("R8", "no stretch", scl_low, 0);
        get_byte(v);
        chk("R6", "second byte", v, 8'h3C);
        msda = 1'b1; idle(H); hi_begin();
        chk("R7", "nack stored", ack_stat, 1);
        hi_end(); idle(6);
        chk("R5", "hold at end", scl_low, 1);
        cpu(3, 0);
        chk("R9", "ack cleared", ack_stat, 0);
        cpu(4, 0);
        chk("R9", "dir cleared", dir_tx, 0);
        cpu(2, 0);
        chk("R9", "frame cleared", frame_flag, 0);
        chk("R10", "still held", scl_low, 1);
        cpu(1, 0); idle(2);
        chk("R10", "dummy read releases", scl_low, 0);
        bus_stop();
        chk("R11", "sda free", sda_low, 0);
    endtask

    task automatic t_write_addr();
        logic b;
        bus_start();
        put_byte(8'h54);
        msda = 1'b1; idle(H); hi_begin();
        chk("R12", "ack", sda_bus, 0);
        hi_end(); idle(6);
        chk("R12", "dir_tx", dir_tx, 0);
        chk("R12", "frame_flag", frame_flag, 0);
        chk("R12", "scl free", scl_low, 0);
        get_bit(b);
        chk("R12", "no data drive", b, 1);
        bus_stop();
    endtask

    task automatic t_stop_mid();
        logic b;
        irq_en = 1'b0;
        bus_start();
        put_byte(8'h55);
        msda = 1'b1; idle(H); hi_begin();
        chk("R4", "flag set", frame_flag, 1);
        chk("R4", "irq masked", irq, 0);
        hi_end(); idle(6);
        cpu(0, 8'hFF); idle(3);
        for (int i = 0; i < 3; i++) get_bit(b);
        chk("R6", "ones sent", b, 1);
        bus_stop(); idle(4);
        chk("R11", "scl free", scl_low, 0);
        chk("R11", "sda free", sda_low, 0);
        mscl = 1'b0; idle(H);
        for (int i = 0; i < 2; i++) begin
            get_bit(b);
            chk("R11", "idle after stop", b, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(5);
        t_reset();
        t_mismatch();
        t_read();
        t_write_addr();
        t_stop_mid();
        idle(10);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule